// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block watches a running BCD calendar and raises an alarm interrupt when the time reaches a programmed value. Software programs six alarm fields (seconds, minutes, hours, day of month, month and a three-digit year) and a control byte. The control byte holds one enable per field and a master enable. On every once-per-second strobe from the calendar, each enabled field is compared against the calendar value presented in that cycle. A hit on any one enabled field is enough; the enabled fields are ORed, not ANDed.

A hit sets a sticky pending bit, and the alarm interrupt output follows that bit. The pending bit stays set until software writes a one to it in the status register. The calendar counters themselves are outside this block. Configuration uses a simple one-cycle write strobe. A separate read address selects a combinational read-back word, so software can see the stored, masked fields and the status.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: Control bits 0 to 5 enable, in this order, the seconds, minutes, hours, day, month and year comparisons. A field whose enable is clear never causes an alarm, even when it matches.
- R2: Control bit 6 is the master enable. While it is clear no comparison takes place and the pending bit is never set.
- R3: The enabled fields are ORed. With several fields enabled, a match on a single one of them sets the pending bit.
- R4: A comparison happens only in a cycle where `sec_tick` is high. A match in that cycle shows on `alarm_pend` after the next rising clock edge. Matches in cycles without the strobe have no effect.
- R5: Register addresses: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 status. Writes are masked. Control and seconds and minutes keep 7 bits, hours and day keep 6 bits, month keeps 5 bits and year keeps 12 bits. A read returns the masked value, zero-extended.
- R6: A match sets the pending bit, which reads as bit 1 of the status register. `alarm_irq` is high exactly while the pending bit is set.
- R7: Writing the status register with bit 1 set clears the pending bit. Other bits of the write have no effect. If a match occurs in the same cycle as the clear, the pending bit stays set.
- R8: Month is compared in the encoding the calendar presents. The year comparison uses all 12 bits, so years that differ only in the hundreds digit do not match.
- R9: Once set, the pending bit stays set through later strobes, whether or not they match, until software clears it.
- R10: After reset, every alarm field, the control register and the pending bit are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, issued after the calendar advances |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 6 | Current hours, BCD |
| cal_day | input | 6 | Current day of month, BCD |
| cal_mon | input | 5 | Current month, BCD |
| cal_year | input | 12 | Current year, three BCD digits |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| cfg_raddr | input | 3 | Register read address |
| cfg_rdata | output | 16 | Read-back data for `cfg_raddr` |
| alarm_pend | output | 1 | Sticky alarm pending bit |
| alarm_irq | output | 1 | Alarm interrupt, follows the pending bit |

## Verification
Most internal faults in this block surface as a wrong `alarm_pend` one clock after a strobe. Examples are a wrong enable bit position, an AND in place of the OR, a master gate that is ignored, or a year compared on fewer bits. A reference model compares the design against its own result on every clock, so such a fault is reported in the cycle after the first strobe it affects. A wrong write mask or address decode shows on the read-back port as soon as that register is read. It can also show later as a missing or false alarm. The same-cycle clear-and-match case is driven on purpose, because a wrong priority there would otherwise go unseen.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
    localparam int NUM_FIELDS = 6;
    localparam int FIELD_W    = 12;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 16;
    localparam int CTRL_W     = NUM_FIELDS + 1;
    localparam int MASTER_BIT = NUM_FIELDS;
    localparam int PEND_BIT   = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_SEC  = 3'd1,
        RA_MIN  = 3'd2,
        RA_HOUR = 3'd3,
        RA_DAY  = 3'd4,
        RA_MON  = 3'd5,
        RA_YEAR = 3'd6,
        RA_STAT = 3'd7
    } reg_addr_e;

    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        field_vec_t        alm;
    } cfg_t;

    // Bits kept per field on a write: sec, min, hour, day, month, year
    function automatic logic [FIELD_W-1:0] field_mask(input int idx);
        case (idx)
            0, 1:    field_mask = 12'h07F;
            2, 3:    field_mask = 12'h03F;
            4:       field_mask = 12'h01F;
            default: field_mask = 12'hFFF;
        endcase
    endfunction
endpackage

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
    import alarm_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (waddr == RA_CTRL) begin
                cfg_d.ctrl = wdata[CTRL_W-1:0];
            end
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (waddr == ADDR_W'(i + 1)) begin
                    cfg_d.alm[i] = wdata[FIELD_W-1:0] & field_mask(i);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_SEC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == RA_SEC) |=> (cfg_q.alm[0][FIELD_W-1:7] == '0)); // R5
    AST_OTHER_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == RA_STAT) |=> $stable(cfg_q)); // R5
endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match
    import alarm_cmp_pkg::*;
(
    input  cfg_t       cfg,
    input  field_vec_t cal,
    output logic       any_hit
);
    logic [NUM_FIELDS-1:0] hit;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign hit[g] = cfg.ctrl[g] && (cal[g] == cfg.alm[g]);
    end

    assign any_hit = cfg.ctrl[MASTER_BIT] && (|hit);
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
    import alarm_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [6:0]        cal_sec,
    input  logic [6:0]        cal_min,
    input  logic [5:0]        cal_hour,
    input  logic [5:0]        cal_day,
    input  logic [4:0]        cal_mon,
    input  logic [11:0]       cal_year,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_waddr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              alarm_pend,
    output logic              alarm_irq
);
    typedef struct packed {
        logic pend;
    } state_t;

    cfg_t       cfg;
    field_vec_t cal;
    logic       any_hit;
    logic       clr_req;
    state_t     st_d, st_q;

    assign cal[0] = FIELD_W'(cal_sec);
    assign cal[1] = FIELD_W'(cal_min);
    assign cal[2] = FIELD_W'(cal_hour);
    assign cal[3] = FIELD_W'(cal_day);
    assign cal[4] = FIELD_W'(cal_mon);
    assign cal[5] = cal_year;

    alarm_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_waddr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    alarm_field_match u_match (
        .cfg     (cfg),
        .cal     (cal),
        .any_hit (any_hit)
    );

    assign clr_req = cfg_we && (cfg_waddr == RA_STAT) && cfg_wdata[PEND_BIT];

    always_comb begin
        st_d = st_q;
        if (clr_req)             st_d.pend = 1'b0;
        if (sec_tick && any_hit) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_raddr == RA_CTRL) cfg_rdata = DATA_W'(cfg.ctrl);
        if (cfg_raddr == RA_STAT) cfg_rdata[PEND_BIT] = st_q.pend;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (cfg_raddr == ADDR_W'(i + 1)) cfg_rdata = DATA_W'(cfg.alm[i]);
        end
    end

    assign alarm_pend = st_q.pend;
    assign alarm_irq  = st_q.pend;

    AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_pend) |-> $past(sec_tick)); // R4
    AST_SET_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_pend) |-> $past(cfg.ctrl[MASTER_BIT])); // R2
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_pend && !clr_req) |=> alarm_pend); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !sec_tick) |=> !alarm_pend); // R7
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq == cfg_rdata[PEND_BIT] || cfg_raddr != RA_STAT); // R6
endmodule

// File: tb/bcd_alarm_cmp_tb.sv
module bcd_alarm_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [6:0]  cal_sec = '0;
    logic [6:0]  cal_min = '0;
    logic [5:0]  cal_hour = '0;
    logic [5:0]  cal_day = '0;
    logic [4:0]  cal_mon = '0;
    logic [11:0] cal_year = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_waddr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  cfg_raddr = '0;
    logic [15:0] cfg_rdata;
    logic        alarm_pend, alarm_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bcd_alarm_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_day(cal_day), .cal_mon(cal_mon), .cal_year(cal_year),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .alarm_pend(alarm_pend), .alarm_irq(alarm_irq)
    );

    // Behavioural reference model
    int m_ctrl;
    int m_alm [6];
    bit m_pend;

    function automatic int cal_val(input int i);
        case (i)
            0: return int'(cal_sec);
            1: return int'(cal_min);
            2: return int'(cal_hour);
            3: return int'(cal_day);
            4: return int'(cal_mon);
            default: return int'(cal_year);
        endcase
    endfunction

    function automatic int keep_bits(input int i);
        if (i < 2) return 'h7F;
        if (i < 4) return 'h3F;
        if (i == 4) return 'h1F;
        return 'hFFF;
    endfunction

    function automatic int model_read(input int a);
        if (a == 0) return m_ctrl;
        if (a == 7) return m_pend ? 2 : 0;
        return m_alm[a-1];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0;
            m_pend = 0;
            for (int i = 0; i < 6; i++) m_alm[i] = 0;
        end else begin
            bit hit;
            hit = 0;
            for (int i = 0; i < 6; i++)
                if (((m_ctrl >> i) & 1) != 0 && cal_val(i) == m_alm[i]) hit = 1;
            hit = hit && sec_tick && ((m_ctrl >> 6) & 1) != 0;
            if (cfg_we && cfg_waddr == 7 && cfg_wdata[1]) m_pend = 0;
            if (hit) m_pend = 1;
            if (cfg_we && cfg_waddr == 0) m_ctrl = int'(cfg_wdata) & 'h7F;
            if (cfg_we && cfg_waddr >= 1 && cfg_waddr <= 6)
                m_alm[cfg_waddr-1] = int'(cfg_wdata) & keep_bits(int'(cfg_waddr) - 1);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R6)
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(alarm_pend == m_pend && alarm_irq == m_pend, "R6 model pend/irq",
                  {alarm_irq, alarm_pend}, {m_pend, m_pend});
            check(int'(cfg_rdata) == model_read(int'(cfg_raddr)), "R5 model rdata",
                  int'(cfg_rdata), model_read(int'(cfg_raddr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = 3'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string tag);
        @(negedge clk);
        cfg_raddr = 3'(a);
        #1;
        check(int'(cfg_rdata) == exp, tag, int'(cfg_rdata), exp);
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic pend_check(input bit exp, input string tag);
        #1;
        check(alarm_pend == exp && alarm_irq == exp, tag, {alarm_irq, alarm_pend}, {exp, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values
        for (int a = 0; a < 8; a++) rd_check(a, 0, "R10 reset register");
        pend_check(0, "R10 reset pend");
        // R5: masking
        for (int a = 0; a < 7; a++) wr(a, 'hFFFF);
        rd_check(0, 'h7F, "R5 ctrl mask");
        rd_check(1, 'h7F, "R5 sec mask");
        rd_check(2, 'h7F, "R5 min mask");
        rd_check(3, 'h3F, "R5 hour mask");
        rd_check(4, 'h3F, "R5 day mask");
        rd_check(5, 'h1F, "R5 month mask");
        rd_check(6, 'hFFF, "R5 year mask");
        wr(0, 0);
        wr(1, 'h30); wr(2, 'h15); wr(3, 'h08); wr(4, 'h21); wr(5, 'h12); wr(6, 'h123);
        cal_day = 6'h01; cal_mon = 5'h01; cal_year = 12'h024;
        // R2: master off
        wr(0, 'h01); cal_sec = 7'h30;
        tick(); pend_check(0, "R2 master clear blocks alarm");
        // R1: disabled matching field
        wr(0, 'h42);
        tick(); pend_check(0, "R1 disabled field ignored");
        // R4: no strobe
        wr(0, 'h41);
        repeat (3) @(negedge clk);
        pend_check(0, "R4 no compare without tick");
        // R6: match
        tick(); pend_check(1, "R6 match sets pend");
        rd_check(7, 2, "R6 status bit1");
        // R9: sticky
        cal_sec = 7'h31;
        tick(); pend_check(1, "R9 pend sticky");
        // R7: clear semantics
        wr(7, 'hFFFD); pend_check(1, "R7 other bits no effect");
        wr(7, 'h2); pend_check(0, "R7 w1c clears");
        // R3: OR of enabled fields, only hour matches
        wr(0, 'h7F); cal_hour = 6'h08;
        tick(); pend_check(1, "R3 single field of many fires");
        wr(7, 'h2);
        // R8: year full width, month encoding
        wr(0, 'h60); cal_year = 12'h023;
        tick(); pend_check(0, "R8 hundreds digit differs");
        cal_year = 12'h123;
        tick(); pend_check(1, "R8 year match");
        wr(7, 'h2);
        wr(0, 'h50); cal_mon = 5'h12;
        tick(); pend_check(1, "R8 month match");
        wr(7, 'h2); pend_check(0, "R7 cleared before race");
        // R7: same-cycle clear and match, match wins
        @(negedge clk);
        sec_tick = 1'b1; cfg_we = 1'b1; cfg_waddr = 3'd7; cfg_wdata = 16'h2;
        @(negedge clk);
        sec_tick = 1'b0; cfg_we = 1'b0;
        pend_check(1, "R7 match wins over clear");
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule